// File: doc/BRIEF.md
# Auto-Stepping Port-Mapped Data RAM

This block puts a word-wide data RAM behind two I/O port codes of a processor whose own address space is too small to hold bulk data. A write to the pointer port loads an address counter and picks a step direction. Each read or write on the data port then accesses the RAM at the counter address and moves the counter one word up or down. Software can then stream through vertex records, or use the RAM as a stack, with no explicit address arithmetic.

The processor bus is synchronous to `clk`. An I/O access is a cycle in which the memory-select line is low and the read or write strobe is high. The port code is decoded on its low three bits only. One strobe cycle is one access.

Top module: `asp_stream_ram`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter clears to address 0 with the step direction set to up, and `rdata` clears to 0.
- R2: A write to port code 3 loads the counter from `wdata[ADDR_W-1:0]`. Bits from ADDR_W up to 13 are ignored. Bit 14 sets the step direction: 1 means down and 0 means up.
- R3: A write to port code 2 stores `wdata` at the current counter address.
- R4: A read of port code 2 presents the word at the current counter address on `rdata` after the clock edge that samples the strobe. `rdata` then holds that word until the next data-port read.
- R5: Every data-port access steps the counter by one in the selected direction after the access. The access itself always uses the address held before the step.
- R6: The counter wraps modulo 2^ADDR_W in both directions, so the maximum address steps up to 0 and address 0 steps down to the maximum.
- R7: Only bits 2:0 of `port_addr` are decoded, so codes 10 and 11 act exactly as codes 2 and 3.
- R8: When `mem_sel` is high, no strobe has any effect on the counter, the direction or the RAM.
- R9: A read of port code 3, and any access to codes other than 2 and 3, leaves the counter, the RAM and `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_addr | input | PORT_W | Port code from the processor address bus |
| mem_sel | input | 1 | High for a memory cycle; I/O ports respond only when it is low |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wdata | input | DATA_W | Write data from the processor |
| rdata | output | DATA_W | Registered read data from the data port |

## Verification
The bench uses a 64-word configuration. It first fills every location upward from reset with an arithmetic pattern. It then reads the whole array back in both directions and runs one step past each end. A reset address other than 0, an off-by-one pre/post-step error, or a broken wrap each give a different misplaced word. Downward writes across address 0 and loads through the aliased codes separate direction handling from decode. Strobes with the memory line high, pointer-port reads and accesses to unused codes are each followed by a data read, which shows whether the counter or the contents moved.

// File: rtl/asp_pkg.sv
// Package: shared port codes for the auto-stepping data RAM.
// Assumes the processor decodes I/O ports on a 3-bit code.
package asp_pkg;
    localparam int SEL_W = 3;
    typedef enum logic [SEL_W-1:0] {
        PORT_DATA = 3'd2,
        PORT_PTR  = 3'd3
    } asp_port_e;
endpackage

// File: rtl/asp_port_decode.sv
// Port decoder: turns bus strobes into data-read, data-write and pointer-load
// pulses. Assumes one strobe cycle per access; upper code bits alias away.
// If both strobes are high together, the write is taken and the read dropped.
module asp_port_decode
    import asp_pkg::*;
#(
    parameter int PORT_W = 4
) (
    input  logic [PORT_W-1:0] port_addr,
    input  logic              mem_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    output logic              data_rd,
    output logic              data_wr,
    output logic              ptr_wr
);
    logic [SEL_W-1:0]        code;
    logic [PORT_W-SEL_W-1:0] unused_hi_code;
    logic                    io_cycle;

    assign code           = port_addr[SEL_W-1:0];
    assign unused_hi_code = port_addr[PORT_W-1:SEL_W];
    assign io_cycle       = !mem_sel;

    // Combinational decode of the three actions the block reacts to.
    always_comb begin
        data_wr = io_cycle && wr_stb && (code == PORT_DATA);
        data_rd = io_cycle && rd_stb && !wr_stb && (code == PORT_DATA);
        ptr_wr  = io_cycle && wr_stb && (code == PORT_PTR);
    end
endmodule

// File: rtl/asp_addr_ctr.sv
// Address counter: loadable pointer with a direction flag; steps one word
// after each data access. Assumes load and step never occur together.
module asp_addr_ctr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_dir,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              dir_down
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // Pointer register: reset, load or step with natural modulo wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr     <= '0;
            dir_down <= 1'b0;
        end else if (load) begin
            addr     <= load_addr;
            dir_down <= load_dir;
        end else if (step) begin
            addr     <= dir_down ? addr - ONE : addr + ONE;
        end
    end

    a_r2_load_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr == $past(load_addr)) && (dir_down == $past(load_dir)));
    a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !dir_down) |=> addr == ADDR_W'($past(addr) + ONE));
    a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && dir_down) |=> addr == ADDR_W'($past(addr) - ONE));
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(addr) && $stable(dir_down));
endmodule

// File: rtl/asp_ram.sv
// Single-port data array with a registered read port. Assumes at most one
// access per cycle; rdata holds its value between reads.
module asp_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Array write at the pre-step address.
    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    // Read register: cleared by reset, loaded only on a data read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= mem[addr];
    end

    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: rtl/asp_stream_ram.sv
// Top: auto-stepping data RAM behind a pointer port and a data port.
// Assumes a synchronous bus with single-cycle strobes; DIR_BIT must lie
// above the address field inside the data word.
module asp_stream_ram #(
    parameter int PORT_W  = 4,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 16,
    parameter int DIR_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_addr,
    input  logic              mem_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic              data_rd;
    logic              data_wr;
    logic              ptr_wr;
    logic [ADDR_W-1:0] cur_addr;
    logic              dir_down;

    asp_port_decode #(.PORT_W(PORT_W)) u_dec (
        .port_addr (port_addr),
        .mem_sel   (mem_sel),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .data_rd   (data_rd),
        .data_wr   (data_wr),
        .ptr_wr    (ptr_wr)
    );

    asp_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_wr),
        .load_addr (wdata[ADDR_W-1:0]),
        .load_dir  (wdata[DIR_BIT]),
        .step      (data_rd || data_wr),
        .addr      (cur_addr),
        .dir_down  (dir_down)
    );

    asp_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (cur_addr),
        .wr_en (data_wr),
        .rd_en (data_rd),
        .wdata (wdata),
        .rdata (rdata)
    );

    a_r7_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_rd, data_wr, ptr_wr}));
    a_r8_mem_cycle_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |=> $stable(cur_addr) && $stable(dir_down) && $stable(rdata));
endmodule

// File: tb/tb_asp_stream_ram.sv
`timescale 1ns/1ps
module tb_asp_stream_ram;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  port_addr = '0;
    logic        mem_sel = 1'b1;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    logic [15:0]   exp_mem [DEPTH];
    logic [AW-1:0] exp_addr = '0;
    logic          exp_dir = 1'b0;
    int            n_checks = 0;
    int            n_errors = 0;
    bit            finished = 1'b0;

    asp_stream_ram #(.PORT_W(4), .ADDR_W(AW), .DATA_W(16), .DIR_BIT(14)) dut (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .mem_sel(mem_sel),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic [3:0] code, input logic msel,
                       input logic rd, input logic wr, input logic [15:0] d);
        @(negedge clk);
        port_addr = code; mem_sel = msel; rd_stb = rd; wr_stb = wr; wdata = d;
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0; mem_sel = 1'b1;
    endtask

    task automatic model_step();
        exp_addr = exp_dir ? exp_addr - 1'b1 : exp_addr + 1'b1;
    endtask

    task automatic load_ptr(input logic [3:0] code, input logic [15:0] w);
        bus(code, 1'b0, 1'b0, 1'b1, w);
        exp_addr = w[AW-1:0];
        exp_dir  = w[14];
    endtask

    task automatic put(input logic [3:0] code, input logic [15:0] d);
        bus(code, 1'b0, 1'b0, 1'b1, d);
        exp_mem[exp_addr] = d;
        model_step();
    endtask

    task automatic get_chk(input logic [3:0] code, input string req);
        bus(code, 1'b0, 1'b1, 1'b0, 16'h0);
        check(rdata === exp_mem[exp_addr], req, rdata, exp_mem[exp_addr]);
        model_step();
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'((i * 16'd4099 + 16'd77) ^ 16'hA5C3);
    endfunction

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(rdata === 16'h0, "R1 rdata after reset", rdata, 16'h0);

        // R1 R3 R5: fill upward from the reset address, no pointer load.
        for (int i = 0; i < DEPTH; i++) put(4'd2, pat(i));
        // R2 R4 R5: read all back upward from 0, then one past the top (R6).
        load_ptr(4'd3, 16'h0000);
        for (int i = 0; i < DEPTH; i++) get_chk(4'd2, "R4 R5 up read");
        get_chk(4'd2, "R6 wrap up to 0");

        // R2: high field bits ignored, bit 14 selects down; R6 wrap down.
        load_ptr(4'd3, 16'h7FC0 | 16'(DEPTH - 1));
        for (int i = 0; i < DEPTH; i++) get_chk(4'd2, "R5 down read");
        get_chk(4'd2, "R6 wrap down to max");

        // R7: aliased codes; R3 downward writes across address 0 (R6).
        load_ptr(4'd11, 16'h4001);
        put(4'd10, 16'h1111); put(4'd10, 16'h2222); put(4'd10, 16'h3333);
        load_ptr(4'd11, 16'h0000 | 16'(DEPTH - 2));
        for (int i = 0; i < 5; i++) get_chk(4'd10, "R7 R6 alias and wrap");

        // R8: strobes with memory-select high change nothing.
        load_ptr(4'd3, 16'h0009);
        bus(4'd2, 1'b1, 1'b0, 1'b1, 16'hDEAD);
        bus(4'd3, 1'b1, 1'b0, 1'b1, 16'h4020);
        bus(4'd2, 1'b1, 1'b1, 1'b0, 16'h0);
        get_chk(4'd2, "R8 mem cycle ignored");
        get_chk(4'd2, "R8 mem cycle ignored next");

        // R9: pointer-port read and other codes leave state and rdata alone.
        held = rdata;
        bus(4'd3, 1'b0, 1'b1, 1'b0, 16'h0);
        check(rdata === held, "R9 ptr read keeps rdata", rdata, held);
        bus(4'd5, 1'b0, 1'b0, 1'b1, 16'h4003);
        bus(4'd0, 1'b0, 1'b1, 1'b0, 16'h0);
        bus(4'd14, 1'b0, 1'b0, 1'b1, 16'hBEEF);
        check(rdata === held, "R9 other ports keep rdata", rdata, held);
        get_chk(4'd2, "R9 counter unchanged");
        get_chk(4'd2, "R9 contents unchanged");

        // R1: reset mid-run returns the counter to 0 going up.
        load_ptr(4'd3, 16'h4020);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(rdata === 16'h0, "R1 rdata cleared by reset", rdata, 16'h0);
        exp_addr = '0; exp_dir = 1'b0;
        get_chk(4'd2, "R1 counter at 0 after reset");
        get_chk(4'd2, "R1 direction up after reset");

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule